// File: doc/BRIEF.md
# Reset Supervisor Sequencer

This block turns digitized supply status and a raw push-button style manual-reset line into one active-low system reset. The supply status arrives as a synchronous "supply below threshold" flag from an external comparator. The manual line is asynchronous and bouncy, so it is synchronized and then qualified by a low-time filter. A qualified request must then survive a further fixed assertion delay before it drives reset low.

Once every cause has cleared, a release timer holds reset low for a programmable number of clock cycles. If any cause returns while that count runs, the count is thrown away and starts over from zero. An asynchronous power-on flag forces reset low at once and clears every counter. The block then recovers exactly as it does after a supply fault. All durations are parameters in clock cycles.

Top module: `rst_sequencer`

## Requirements
- R1: `rst_n` is active-low. While `por_n` is low, `rst_n` is low without waiting for a clock edge, and every internal counter is cleared.
- R2: After `por_n` rises with no cause active, `rst_n` stays low through TIMEOUT_CYC-1 rising edges and goes high on the TIMEOUT_CYC-th rising edge.
- R3: When `sup_low` is sampled high on a rising edge, `rst_n` is low after that edge. It stays low for as long as `sup_low` is high.
- R4: After `sup_low` returns low, `rst_n` goes high on the TIMEOUT_CYC-th consecutive rising edge at which no cause is active, and not before.
- R5: A cause that appears while the release count is running clears the count. Release then needs a full TIMEOUT_CYC quiet edges after that cause ends.
- R6: `mr_raw_n` passes through a two-stage synchronizer. A low run of fewer than FILTER_CYC synchronized samples leaves `rst_n` unchanged, and any high sample restarts the filter.
- R7: Once the filter qualifies a request, a further DELAY_CYC cycles pass before the request counts as a cause. `rst_n` falls on the edge FILTER_CYC+DELAY_CYC+3 after `mr_raw_n` is first sampled low. A low run of exactly FILTER_CYC+DELAY_CYC-1 edges is the shortest run that produces a reset.
- R8: A qualified request that ends before its assertion delay completes leaves `rst_n` high.
- R9: `rst_n` stays low while `mr_raw_n` is held low. It goes high on the edge TIMEOUT_CYC+4 after `mr_raw_n` is first sampled high again, the extra edges covering the synchronizer, the filter and the request stage.
- R10: `rst_n` is high only while `sup_low` is low, no manual request is active, and the release count has expired. A cause held across the other cause's recovery keeps reset low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on flag, low forces reset and clears counters |
| sup_low | input | 1 | Synchronous flag, high when supply is below threshold |
| mr_raw_n | input | 1 | Raw asynchronous manual-reset line, low requests a reset |
| rst_n | output | 1 | Registered active-low system reset |

## Verification
A supply fault shows on `rst_n` one edge after `sup_low` is sampled. A manual request shows FILTER_CYC+DELAY_CYC+3 edges after the line is first sampled low. Release comes TIMEOUT_CYC edges after the supply flag clears, or TIMEOUT_CYC+4 edges after the manual line rises. Every vector in the bench drives its inputs on a falling edge, waits a counted number of falling edges, and samples `rst_n` there. Each boundary is checked twice: once on the last edge before the change is due and once on the edge where it is due.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

   // bits needed to hold the values 0..n
   function automatic int unsigned span_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

   localparam int unsigned SYNC_MIN = 2;

endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic d_i,
   output logic q_o
);
   import rst_seq_pkg::*;

   generate
      if (STAGES < SYNC_MIN) begin : g_bad_stages
         $error("rst_seq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   // preset to the inactive (high) level so power-on never looks like a press
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rst_seq_mr_filter.sv
module rst_seq_mr_filter #(
   parameter int unsigned FILTER_CYC = 4
) (
   input  logic clk,
   input  logic por_n,
   input  logic mr_sync_n_i,
   output logic qual_o
);
   import rst_seq_pkg::*;

   localparam int unsigned FW = span_bits(FILTER_CYC);
   localparam logic [FW-1:0] LAST = FW'(FILTER_CYC - 1);
   localparam logic [FW-1:0] TOP  = FW'(FILTER_CYC);

   generate
      if (FILTER_CYC < 1) begin : g_bad_filter
         $error("rst_seq_mr_filter: FILTER_CYC must be at least 1");
      end
   endgenerate

   logic [FW-1:0] low_cnt_q;
   logic          qual_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         low_cnt_q <= '0;
         qual_q    <= 1'b0;
      end else if (mr_sync_n_i) begin
         low_cnt_q <= '0;
         qual_q    <= 1'b0;
      end else begin
         if (low_cnt_q != TOP) low_cnt_q <= low_cnt_q + FW'(1);
         qual_q <= (low_cnt_q >= LAST);
      end
   end

   assign qual_o = qual_q;
endmodule

// File: rtl/rst_seq_assert_dly.sv
module rst_seq_assert_dly #(
   parameter int unsigned DELAY_CYC = 3
) (
   input  logic clk,
   input  logic por_n,
   input  logic qual_i,
   output logic req_o
);
   import rst_seq_pkg::*;

   generate
      if (DELAY_CYC < 1) begin : g_bad_delay
         $error("rst_seq_assert_dly: DELAY_CYC must be at least 1");
      end

      if (DELAY_CYC == 1) begin : g_single
         logic req_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) req_q <= 1'b0;
            else        req_q <= qual_i;
         end
         assign req_o = req_q;
      end else begin : g_count
         localparam int unsigned DW = span_bits(DELAY_CYC);
         localparam logic [DW-1:0] LAST = DW'(DELAY_CYC - 1);
         localparam logic [DW-1:0] TOP  = DW'(DELAY_CYC);
         logic [DW-1:0] dly_q;
         logic          req_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               dly_q <= '0;
               req_q <= 1'b0;
            end else if (!qual_i) begin
               dly_q <= '0;
               req_q <= 1'b0;
            end else begin
               if (dly_q != TOP) dly_q <= dly_q + DW'(1);
               req_q <= (dly_q >= LAST);
            end
         end
         assign req_o = req_q;
      end
   endgenerate
endmodule

// File: rtl/rst_seq_release.sv
module rst_seq_release #(
   parameter int unsigned TIMEOUT_CYC = 10
) (
   input  logic clk,
   input  logic por_n,
   input  logic cause_i,
   output logic rst_n_o
);
   import rst_seq_pkg::*;

   generate
      if (TIMEOUT_CYC < 1) begin : g_bad_timeout
         $error("rst_seq_release: TIMEOUT_CYC must be at least 1");
      end

      if (TIMEOUT_CYC == 1) begin : g_direct
         logic rst_n_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) rst_n_q <= 1'b0;
            else        rst_n_q <= !cause_i;
         end
         assign rst_n_o = rst_n_q;
      end else begin : g_timed
         localparam int unsigned TW = span_bits(TIMEOUT_CYC - 1);
         localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYC - 1);
         logic [TW-1:0] quiet_q;
         logic          rst_n_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               quiet_q <= '0;
               rst_n_q <= 1'b0;
            end else if (cause_i) begin
               quiet_q <= '0;
               rst_n_q <= 1'b0;
            end else if (!rst_n_q) begin
               if (quiet_q == LAST) begin
                  quiet_q <= '0;
                  rst_n_q <= 1'b1;
               end else begin
                  quiet_q <= quiet_q + TW'(1);
               end
            end
         end
         assign rst_n_o = rst_n_q;
      end
   endgenerate
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer #(
   parameter int unsigned FILTER_CYC  = 1250,
   parameter int unsigned DELAY_CYC   = 600,
   parameter int unsigned TIMEOUT_CYC = 7000000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic sup_low,
   input  logic mr_raw_n,
   output logic rst_n
);
   logic mr_sync_n;
   logic mr_qual;
   logic mr_req;
   logic cause;

   rst_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .por_n (por_n),
      .d_i   (mr_raw_n),
      .q_o   (mr_sync_n)
   );

   rst_seq_mr_filter #(.FILTER_CYC(FILTER_CYC)) u_filter (
      .clk         (clk),
      .por_n       (por_n),
      .mr_sync_n_i (mr_sync_n),
      .qual_o      (mr_qual)
   );

   rst_seq_assert_dly #(.DELAY_CYC(DELAY_CYC)) u_delay (
      .clk    (clk),
      .por_n  (por_n),
      .qual_i (mr_qual),
      .req_o  (mr_req)
   );

   assign cause = sup_low | mr_req;

   rst_seq_release #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_release (
      .clk     (clk),
      .por_n   (por_n),
      .cause_i (cause),
      .rst_n_o (rst_n)
   );
endmodule

// File: rtl/rst_sequencer_chk.sv
module rst_sequencer_chk #(
   parameter int unsigned TIMEOUT_CYC = 10
) (
   input logic clk,
   input logic por_n,
   input logic sup_low,
   input logic mr_req,
   input logic rst_n
);
   // consecutive quiet edges seen while reset was still held
   logic [31:0] quiet_seen;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                quiet_seen <= '0;
      else if (sup_low || mr_req) quiet_seen <= '0;
      else if (!rst_n && quiet_seen != '1) quiet_seen <= quiet_seen + 32'd1;
   end

   // R1: power-on flag holds reset low
   always @(posedge clk) begin
      if (!por_n) begin
         p_por_low_r1: assert (!rst_n);
      end
   end

   // R3: supply fault forces reset on the next edge
   p_brownout_r3: assert property (@(posedge clk) disable iff (!por_n)
      sup_low |=> !rst_n);

   // R9: an active manual request keeps reset low
   p_mr_hold_r9: assert property (@(posedge clk) disable iff (!por_n)
      mr_req |=> !rst_n);

   // R10: release only when both causes were inactive
   p_release_clear_r10: assert property (@(posedge clk) disable iff (!por_n)
      $rose(rst_n) |-> (!$past(sup_low) && !$past(mr_req)));

   // R4: release only after the full quiet window
   p_full_window_r4: assert property (@(posedge clk) disable iff (!por_n)
      $rose(rst_n) |-> (quiet_seen == 32'(TIMEOUT_CYC)));
endmodule

bind rst_sequencer rst_sequencer_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
   .clk     (clk),
   .por_n   (por_n),
   .sup_low (sup_low),
   .mr_req  (mr_req),
   .rst_n   (rst_n)
);

// File: tb/tb_rst_sequencer.sv
`timescale 1ns/1ps
module tb_rst_sequencer;
   localparam int unsigned F = 4;
   localparam int unsigned D = 3;
   localparam int unsigned T = 10;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic sup_low = 1'b0;
   logic mr_raw_n = 1'b1;
   logic rst_n;
   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rst_sequencer #(.FILTER_CYC(F), .DELAY_CYC(D), .TIMEOUT_CYC(T), .SYNC_STAGES(2)) dut (
      .clk(clk), .por_n(por_n), .sup_low(sup_low), .mr_raw_n(mr_raw_n), .rst_n(rst_n)
   );

   typedef struct packed {
      logic       sup;
      logic       mr_n;
      logic [7:0] n;
      logic       exp;
      logic [3:0] rq;
   } vec_t;

   localparam int NV = 32;
   localparam vec_t VEC [0:NV-1] = '{
      '{1'b1, 1'b1, 8'd1,  1'b0, 4'd3},   // R3 fault seen at next edge
      '{1'b1, 1'b1, 8'd20, 1'b0, 4'd3},   // R3 held
      '{1'b0, 1'b1, 8'd9,  1'b0, 4'd4},   // R4 one edge short
      '{1'b0, 1'b1, 8'd1,  1'b1, 4'd4},   // R4 release at T
      '{1'b0, 1'b0, 8'd9,  1'b1, 4'd7},   // R7 F+D+2 edges: still high
      '{1'b0, 1'b0, 8'd1,  1'b0, 4'd7},   // R7 F+D+3 edges: low
      '{1'b0, 1'b0, 8'd30, 1'b0, 4'd9},   // R9 held low
      '{1'b0, 1'b1, 8'd13, 1'b0, 4'd9},   // R9 T+3 after rise
      '{1'b0, 1'b1, 8'd1,  1'b1, 4'd9},   // R9 T+4 after rise
      '{1'b0, 1'b0, 8'd3,  1'b1, 4'd6},   // R6 short pulse
      '{1'b0, 1'b1, 8'd6,  1'b1, 4'd6},   // R6 ignored
      '{1'b0, 1'b1, 8'd20, 1'b1, 4'd6},   // R6 ignored
      '{1'b0, 1'b0, 8'd5,  1'b1, 4'd8},   // R8 qualified but delay cut
      '{1'b0, 1'b1, 8'd6,  1'b1, 4'd8},   // R8
      '{1'b0, 1'b1, 8'd20, 1'b1, 4'd8},   // R8
      '{1'b0, 1'b0, 8'd6,  1'b1, 4'd7},   // R7 shortest effective pulse
      '{1'b0, 1'b1, 8'd3,  1'b1, 4'd7},   // R7 edge 9: still high
      '{1'b0, 1'b1, 8'd1,  1'b0, 4'd7},   // R7 edge 10: low
      '{1'b0, 1'b1, 8'd9,  1'b0, 4'd9},   // R9
      '{1'b0, 1'b1, 8'd1,  1'b1, 4'd9},   // R9 release at edge 20
      '{1'b1, 1'b1, 8'd1,  1'b0, 4'd5},   // R5 fault
      '{1'b0, 1'b1, 8'd5,  1'b0, 4'd5},   // R5 partial count
      '{1'b1, 1'b1, 8'd1,  1'b0, 4'd5},   // R5 fault again mid count
      '{1'b0, 1'b1, 8'd9,  1'b0, 4'd5},   // R5 count restarted
      '{1'b0, 1'b1, 8'd1,  1'b1, 4'd5},   // R5 full window
      '{1'b0, 1'b0, 8'd10, 1'b0, 4'd10},  // R10 manual reset in effect
      '{1'b1, 1'b0, 8'd5,  1'b0, 4'd10},  // R10 both causes
      '{1'b0, 1'b0, 8'd20, 1'b0, 4'd10},  // R10 manual still holds
      '{1'b0, 1'b1, 8'd13, 1'b0, 4'd10},  // R10
      '{1'b0, 1'b1, 8'd1,  1'b1, 4'd10},  // R10 release
      '{1'b0, 1'b1, 8'd40, 1'b1, 4'd10},  // R10 stays released
      '{1'b1, 1'b0, 8'd1,  1'b0, 4'd3}    // R3 fault with press pending
   };

   task automatic chk(input logic got, input logic exp, input string req, input string what);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s %s: rst_n=%b expected %b at %0t", req, what, got, exp, $time);
      end
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: run did not complete, expected finish");
         summary();
         $finish;
      end
   end

   initial begin
      // R1 reset state
      #3 chk(rst_n, 1'b0, "R1", "por low before clocks");
      repeat (3) @(negedge clk);
      chk(rst_n, 1'b0, "R1", "por low with clocks");
      por_n = 1'b1;
      // R2 release after power-on
      repeat (T - 1) @(negedge clk);
      chk(rst_n, 1'b0, "R2", "one edge before timeout");
      @(negedge clk);
      chk(rst_n, 1'b1, "R2", "timeout reached");

      for (int i = 0; i < NV; i++) begin
         sup_low  = VEC[i].sup;
         mr_raw_n = VEC[i].mr_n;
         repeat (int'(VEC[i].n)) @(negedge clk);
         chk(rst_n, VEC[i].exp, $sformatf("R%0d", VEC[i].rq), $sformatf("vector %0d", i));
      end

      // back to a quiet state
      sup_low = 1'b0; mr_raw_n = 1'b1;
      repeat (T + 6) @(negedge clk);
      chk(rst_n, 1'b1, "R4", "quiet before por test");

      // R1 asynchronous power-on mid cycle, counters cleared
      @(posedge clk);
      #4 por_n = 1'b0;
      #1 chk(rst_n, 1'b0, "R1", "async por assert");
      @(negedge clk);
      por_n = 1'b1;
      repeat (T - 1) @(negedge clk);
      chk(rst_n, 1'b0, "R2", "repeat por one short");
      @(negedge clk);
      chk(rst_n, 1'b1, "R2", "repeat por release");

      // R1 power-on during a partial release count clears it
      sup_low = 1'b1;
      @(negedge clk);
      sup_low = 1'b0;
      repeat (6) @(negedge clk);
      por_n = 1'b0;
      #2 por_n = 1'b1;
      repeat (T - 1) @(negedge clk);
      chk(rst_n, 1'b0, "R1", "count cleared by por");
      @(negedge clk);
      chk(rst_n, 1'b1, "R1", "full window after por");

      // R6 filter restarts on a high sample: two short runs with one high gap
      mr_raw_n = 1'b0;
      repeat (3) @(negedge clk);
      mr_raw_n = 1'b1;
      @(negedge clk);
      mr_raw_n = 1'b0;
      repeat (3) @(negedge clk);
      mr_raw_n = 1'b1;
      repeat (T + 10) @(negedge clk);
      chk(rst_n, 1'b1, "R6", "split low runs ignored");

      done = 1'b1;
      summary();
      $finish;
   end
endmodule